// File: doc/BRIEF.md
# DDR SDRAM Bank State Checker

This block sits beside the command bus of a double-data-rate SDRAM and judges every registered command against a model of the device. It decodes the four strobe lines into a command. It keeps a state machine for each bank, including the timed states that last a programmable number of clocks. It also keeps a device-wide lockout state for refresh and mode programming. Any command that the addressed bank, or the device as a whole, may not accept in its present state raises a one-cycle violation pulse with a reason code. A rejected command changes no state.

Each bank machine has eight named states. Idle goes to Opening on Activate, and Opening goes to Open once the activate delay has run. Open goes to Reading or Writing on a burst, and back to Open when the burst runs out or is terminated. Open, Reading and Writing go to Closing on Precharge, and Closing goes back to Idle after the precharge delay. A burst with auto-precharge goes to Reading-AutoClose or Writing-AutoClose, and from there to Idle. The device machine has three states: Open; Refreshing, entered on Auto Refresh and left after the refresh delay; and ModeLoad, entered on Mode Register Set and left after the mode delay. The bench and the verification flow use the reported states to follow the bus cycle by cycle.

Top module: `ddr_bank_guard`

## Requirements
- R1: With chip select low, the {row strobe, column strobe, write enable} levels decode as HHH No-Op, LHH Activate, LLH Auto Refresh, LLL Mode Register Set, HLH Read, HLL Write, LHL Precharge and HHL Burst Terminate. With chip select high the command is Deselect whatever the other lines carry. Deselect and No-Op never cause a violation or a state change.
- R2: After reset every bank reports Idle (code 0), the violation output is low and the violation code is 0.
- R3: A command is judged and acted on only when clock enable was high at both the previous and the current rising edge. Any other command is ignored, with no violation and no state change.
- R4: Bank states are reported 3 bits per bank, bank b at bits [3b+2:3b]: Idle 0, Opening 1, Open 2, Reading 3, Writing 4, Closing 5, Reading-AutoClose 6, Writing-AutoClose 7. An Activate to an Idle bank at edge n enters Opening. A command at edge n+T_RCD finds the bank Open.
- R5: An Open bank accepts Read, Write and Precharge. A Read or Write without auto-precharge at edge n enters Reading or Writing, and a command at edge n+BURST_LEN/2 finds the bank Open again. A Precharge at edge n enters Closing, and a command at edge n+T_RP finds the bank Idle.
- R6: A Reading bank accepts Read and Precharge. A Writing bank accepts Read, Write and Precharge. Read enters Reading, Write enters Writing and Precharge enters Closing.
- R7: A bank in Opening, Closing, Reading-AutoClose or Writing-AutoClose rejects Activate, Read, Write and Precharge addressed to it with code 1 (bank busy). Commands to other banks are judged by their own states.
- R8: A Read or Write with the auto-precharge flag high at edge n enters Reading-AutoClose or Writing-AutoClose, and a command at edge n+BURST_LEN/2+T_RP finds the bank Idle. The flag is consulted only with Read and Write.
- R9: Auto Refresh and Mode Register Set are accepted only when every bank is Idle, and are otherwise rejected with code 3.
- R10: After an accepted Auto Refresh (Mode Register Set) at edge n, every command other than Deselect and No-Op is rejected with code 4 through edge n+T_RFC-1 (n+T_MRD-1). From edge n+T_RFC (n+T_MRD) the device accepts commands again.
- R11: Burst Terminate ignores the bank address and acts on the bank of the most recently accepted Read. If that bank is still in Reading, the bank returns to Open. Otherwise the command is rejected with code 5.
- R12: Every other pairing of a bank state and a bank command is rejected with code 2 (wrong state): Read, Write or Precharge to Idle; Activate to Open, Reading or Writing; Write to Reading. A rejected command leaves every bank state unchanged.
- R13: The verdict on the command at edge n appears after edge n for exactly one cycle. The violation output is high and the code nonzero when the command was rejected. Both are 0 when it was accepted or not a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | BA_W | Addressed bank |
| auto_pre | input | 1 | Auto-precharge flag for Read and Write |
| bank_state | output | 3*NUM_BANKS | Per-bank state code |
| viol | output | 1 | Violation pulse for the previous edge's command |
| viol_code | output | 3 | Reason: 0 none, 1 busy, 2 wrong state, 3 not all idle, 4 locked, 5 no burst |

## Verification
The bench builds the block with two banks, T_RCD 2, T_RP 3, T_RFC 5, T_MRD 2 and a burst length of 8. These short delays let every timed state be reached in a few commands, and its last busy edge and first free edge can each be hit exactly. Every one of the eight bank states is paired with each of the four bank commands. Two banks are enough to show per-bank independence and a Burst Terminate that follows the most recent Read across banks.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_REF,
        CMD_MRS,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BST
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE     = 3'd0,
        BK_OPENING  = 3'd1,
        BK_OPEN     = 3'd2,
        BK_READ     = 3'd3,
        BK_WRITE    = 3'd4,
        BK_CLOSING  = 3'd5,
        BK_READ_AC  = 3'd6,
        BK_WRITE_AC = 3'd7
    } bank_st_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_BUSY     = 3'd1,
        ERR_STATE    = 3'd2,
        ERR_NOT_IDLE = 3'd3,
        ERR_LOCKED   = 3'd4,
        ERR_NO_BURST = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        DEV_OPEN,
        DEV_REFRESH,
        DEV_MODE
    } dev_st_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_BST;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_guard_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     cmd,
    input  logic     ap,
    input  logic     go,
    input  logic     bst_go,
    output bank_st_e eff_st,
    output err_e     verdict
);

    localparam int HALF    = BURST_LEN / 2;
    localparam int AC_SPAN = HALF + T_RP;
    localparam int LONGEST = (T_RCD > AC_SPAN) ? T_RCD : AC_SPAN;
    localparam int CW      = $clog2(LONGEST + 1);

    localparam logic [CW-1:0] LD_RCD   = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_BURST = CW'(HALF - 1);
    localparam logic [CW-1:0] LD_AC    = CW'(AC_SPAN - 1);

    bank_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // A timed state whose counter has run out is judged as its successor.
    always_comb begin
        eff_st = state_q;
        if (cnt_q == '0) begin
            unique case (state_q)
                BK_OPENING, BK_READ, BK_WRITE:       eff_st = BK_OPEN;
                BK_CLOSING, BK_READ_AC, BK_WRITE_AC: eff_st = BK_IDLE;
                default:                             eff_st = state_q;
            endcase
        end
    end

    always_comb begin
        verdict = ERR_NONE;
        unique case (eff_st)
            BK_IDLE:  if (cmd inside {CMD_RD, CMD_WR, CMD_PRE}) verdict = ERR_STATE;
            BK_OPEN:  if (cmd == CMD_ACT) verdict = ERR_STATE;
            BK_READ:  if (cmd inside {CMD_ACT, CMD_WR}) verdict = ERR_STATE;
            BK_WRITE: if (cmd == CMD_ACT) verdict = ERR_STATE;
            default:  if (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE}) verdict = ERR_BUSY;
        endcase
    end

    always_comb begin
        state_d = eff_st;
        cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        if (bst_go) begin
            state_d = BK_OPEN;
            cnt_d   = '0;
        end else if (go && verdict == ERR_NONE) begin
            unique case (cmd)
                CMD_ACT: begin
                    state_d = BK_OPENING;
                    cnt_d   = LD_RCD;
                end
                CMD_RD: begin
                    state_d = ap ? BK_READ_AC : BK_READ;
                    cnt_d   = ap ? LD_AC : LD_BURST;
                end
                CMD_WR: begin
                    state_d = ap ? BK_WRITE_AC : BK_WRITE;
                    cnt_d   = ap ? LD_AC : LD_BURST;
                end
                CMD_PRE: begin
                    state_d = BK_CLOSING;
                    cnt_d   = LD_RP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,   // power of two
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        bank_addr,
    input  logic                   auto_pre,
    output logic [NUM_BANKS*3-1:0] bank_state,
    output logic                   viol,
    output logic [2:0]             viol_code
);

    localparam int LOCK_MAX = (T_RFC > T_MRD) ? T_RFC : T_MRD;
    localparam int LW       = $clog2(LOCK_MAX + 1);

    cmd_e           cmd;
    logic           cke_q;
    logic           checked;
    logic           bank_cmd;
    dev_st_e        dev_q, dev_d, dev_eff;
    logic [LW-1:0]  lock_q, lock_d;
    logic [BA_W-1:0] rd_bank_q;
    logic           rd_valid_q;
    logic           all_idle;
    err_e           err;
    bank_st_e       eff_st  [NUM_BANKS];
    err_e           verdict [NUM_BANKS];
    logic [NUM_BANKS-1:0] go;
    logic [NUM_BANKS-1:0] bst_go;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign checked  = cke && cke_q;
    assign bank_cmd = cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE};
    assign dev_eff  = (lock_q == '0) ? DEV_OPEN : dev_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign go[b]     = checked && dev_eff == DEV_OPEN && bank_cmd &&
                           bank_addr == BA_W'(b);
        assign bst_go[b] = checked && cmd == CMD_BST && err == ERR_NONE &&
                           rd_bank_q == BA_W'(b);

        ddr_bank_track #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .BURST_LEN (BURST_LEN)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .ap      (auto_pre),
            .go      (go[b]),
            .bst_go  (bst_go[b]),
            .eff_st  (eff_st[b]),
            .verdict (verdict[b])
        );

        assign bank_state[b*3 +: 3] = eff_st[b];
    end

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (eff_st[b] != BK_IDLE) all_idle = 1'b0;
        end
    end

    // Verdict on the command at this edge; device lockout outranks all else.
    always_comb begin
        err = ERR_NONE;
        if (checked && !(cmd inside {CMD_DESEL, CMD_NOP})) begin
            if (dev_eff != DEV_OPEN) begin
                err = ERR_LOCKED;
            end else begin
                unique case (cmd)
                    CMD_REF, CMD_MRS: err = all_idle ? ERR_NONE : ERR_NOT_IDLE;
                    CMD_BST: err = (rd_valid_q && eff_st[rd_bank_q] == BK_READ) ?
                                   ERR_NONE : ERR_NO_BURST;
                    default: err = verdict[bank_addr];
                endcase
            end
        end
    end

    always_comb begin
        dev_d  = dev_eff;
        lock_d = (lock_q == '0) ? '0 : lock_q - 1'b1;
        if (checked && err == ERR_NONE) begin
            unique case (cmd)
                CMD_REF: begin
                    dev_d  = DEV_REFRESH;
                    lock_d = LW'(T_RFC - 1);
                end
                CMD_MRS: begin
                    dev_d  = DEV_MODE;
                    lock_d = LW'(T_MRD - 1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q      <= 1'b0;
            dev_q      <= DEV_OPEN;
            lock_q     <= '0;
            rd_bank_q  <= '0;
            rd_valid_q <= 1'b0;
            viol       <= 1'b0;
            viol_code  <= 3'd0;
        end else begin
            cke_q     <= cke;
            dev_q     <= dev_d;
            lock_q    <= lock_d;
            viol      <= (err != ERR_NONE);
            viol_code <= err;
            if (checked && err == ERR_NONE && cmd == CMD_RD) begin
                rd_bank_q  <= bank_addr;
                rd_valid_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_bank_guard_chk.sv
module ddr_bank_guard_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic                   viol,
    input logic [2:0]             viol_code
);

    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (bank_state == '0 && !viol && viol_code == 3'd0));

    assert_cke_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(cke));

    assert_quiet_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> viol_code == 3'd0);

    assert_reason_given_R13: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> viol_code != 3'd0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [2:0] st;
        assign st = bank_state[b*3 +: 3];

        assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st) == 3'd0 && st != 3'd0) |-> st == 3'd1);

        assert_closing_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(st) == 3'd5 |-> (st == 3'd5 || st == 3'd0));

        assert_autoclose_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st) == 3'd6 && st != 3'd6) |-> st == 3'd0);
    end

endmodule

bind ddr_bank_guard ddr_bank_guard_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .bank_state (bank_state),
    .viol       (viol),
    .viol_code  (viol_code)
);

// File: tb/ddr_bank_guard_tb.sv
module ddr_bank_guard_tb;
    import ddr_guard_pkg::*;

    localparam int NB   = 2;
    localparam int RCD  = 2;
    localparam int RP   = 3;
    localparam int RFC  = 5;
    localparam int MRD  = 2;
    localparam int BL   = 8;
    localparam int HALF = BL / 2;
    localparam int BA_W = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0] bank_addr = '0;
    logic auto_pre = 1'b0;
    logic [NB*3-1:0] bank_state;
    logic viol;
    logic [2:0] viol_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ddr_bank_guard #(
        .NUM_BANKS (NB), .T_RCD (RCD), .T_RP (RP),
        .T_RFC (RFC), .T_MRD (MRD), .BURST_LEN (BL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .bank_addr (bank_addr), .auto_pre (auto_pre),
        .bank_state (bank_state), .viol (viol), .viol_code (viol_code)
    );

    // Drive one command for one edge; returns at the following falling edge.
    task automatic issue(input cmd_e c, input int b = 0, input bit ap = 1'b0);
        logic [3:0] p;
        unique case (c)
            CMD_DESEL: p = 4'b1000;
            CMD_NOP:   p = 4'b0111;
            CMD_ACT:   p = 4'b0011;
            CMD_REF:   p = 4'b0001;
            CMD_MRS:   p = 4'b0000;
            CMD_RD:    p = 4'b0101;
            CMD_WR:    p = 4'b0100;
            CMD_PRE:   p = 4'b0010;
            default:   p = 4'b0110;
        endcase
        {cs_n, ras_n, cas_n, we_n} = p;
        bank_addr = BA_W'(b);
        auto_pre  = ap;
        @(negedge clk);
    endtask

    task automatic nops(input int k);
        for (int i = 0; i < k; i++) issue(CMD_NOP);
    endtask

    task automatic chk_code(input int exp, input string tag);
        n_tests++;
        if (viol !== (exp != 0) || viol_code !== 3'(exp)) begin
            n_fail++;
            $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
                     tag, viol, viol_code, exp != 0, exp);
        end
    endtask

    task automatic chk_state(input int b, input int exp, input string tag);
        n_tests++;
        if (bank_state[b*3 +: 3] !== 3'(exp)) begin
            n_fail++;
            $display("FAIL %s: bank%0d state=%0d expected %0d",
                     tag, b, bank_state[b*3 +: 3], exp);
        end
    endtask

    task automatic fresh();
        rst_n = 1'b0;
        cke   = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        issue(CMD_NOP);   // first edge has no prior clock-enable sample
    endtask

    function automatic cmd_e bank_cmd(input int i);
        unique case (i)
            0:       return CMD_ACT;
            1:       return CMD_RD;
            2:       return CMD_WR;
            default: return CMD_PRE;
        endcase
    endfunction

    // R7/R12/R5/R6 legality table
    function automatic int exp_err(input int s, input int ci);
        if (s == 1 || s >= 5) return 1;
        case (s)
            0:       return (ci == 0) ? 0 : 2;
            2:       return (ci == 0) ? 2 : 0;
            3:       return (ci == 0 || ci == 2) ? 2 : 0;
            default: return (ci == 0) ? 2 : 0;
        endcase
    endfunction

    function automatic int exp_next(input int s, input int ci);
        if (exp_err(s, ci) != 0) return s;
        case (ci)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    task automatic reach(input int s);
        fresh();
        if (s == 0) return;
        issue(CMD_ACT, 0);
        if (s == 1) return;
        nops(RCD - 1);
        case (s)
            3: issue(CMD_RD, 0);
            4: issue(CMD_WR, 0);
            5: issue(CMD_PRE, 0);
            6: issue(CMD_RD, 0, 1'b1);
            7: issue(CMD_WR, 0, 1'b1);
            default: ;
        endcase
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        fresh();
        chk_state(0, 0, "R2 bank0 idle");
        chk_state(1, 0, "R2 bank1 idle");
        chk_code(0, "R2 no violation");

        // Sweep: every bank state against every bank command (R4-R8, R12)
        for (int s = 0; s < 8; s++) begin
            for (int ci = 0; ci < 4; ci++) begin
                reach(s);
                chk_state(0, s, "R4 setup state");
                issue(bank_cmd(ci), 0);
                chk_code(exp_err(s, ci), $sformatf("R12 state %0d cmd %0d", s, ci));
                if (s == 0 || s == 2)
                    chk_state(0, exp_next(s, ci), $sformatf("R6 next %0d/%0d", s, ci));
            end
        end

        // R4: activate delay
        fresh();
        issue(CMD_ACT, 0);
        chk_state(0, 1, "R4 opening");
        nops(RCD - 1);
        chk_state(0, 2, "R4 open after T_RCD");
        issue(CMD_RD, 0);
        chk_code(0, "R4 read at n+T_RCD");

        // R5: burst runs out
        chk_state(0, 3, "R5 reading");
        nops(HALF - 2);
        chk_state(0, 3, "R5 still reading");
        issue(CMD_NOP);
        chk_state(0, 2, "R5 open after burst");

        // R5: precharge delay
        issue(CMD_PRE, 0);
        chk_state(0, 5, "R5 closing");
        nops(RP - 2);
        chk_state(0, 5, "R5 still closing");
        issue(CMD_NOP);
        chk_state(0, 0, "R5 idle after T_RP");

        // R8: read with auto-precharge
        issue(CMD_ACT, 0);
        nops(RCD - 1);
        issue(CMD_RD, 0, 1'b1);
        chk_state(0, 6, "R8 auto-close");
        nops(HALF + RP - 2);
        chk_state(0, 6, "R8 still auto-close");
        issue(CMD_NOP);
        chk_state(0, 0, "R8 idle");
        issue(CMD_ACT, 0);
        chk_code(0, "R8 activate after auto-close");

        // R7: other bank unaffected by a busy bank
        fresh();
        issue(CMD_ACT, 0);
        issue(CMD_ACT, 1);
        chk_code(0, "R7 other bank activate");
        chk_state(1, 1, "R7 bank1 opening");

        // R11: burst terminate follows most recent read
        issue(CMD_NOP);
        issue(CMD_RD, 0);
        issue(CMD_RD, 1);
        issue(CMD_BST, 0);
        chk_code(0, "R11 terminate accepted");
        chk_state(1, 2, "R11 bank1 open");
        chk_state(0, 3, "R11 bank0 still reading");
        issue(CMD_BST, 0);
        chk_code(5, "R11 no burst left");
        fresh();
        issue(CMD_BST, 1);
        chk_code(5, "R11 terminate with no read");
        issue(CMD_ACT, 0);
        nops(RCD - 1);
        issue(CMD_RD, 0, 1'b1);
        issue(CMD_BST, 0);
        chk_code(5, "R11 terminate on auto-close read");

        // R13: pulse lasts one cycle
        issue(CMD_NOP);
        chk_code(0, "R13 pulse cleared");

        // R9/R10: refresh
        fresh();
        issue(CMD_REF);
        chk_code(0, "R9 refresh all idle");
        issue(CMD_ACT, 0);
        chk_code(4, "R10 locked first edge");
        nops(RFC - 3);
        issue(CMD_BST);
        chk_code(4, "R10 locked last edge");
        issue(CMD_ACT, 0);
        chk_code(0, "R10 free at n+T_RFC");
        chk_state(0, 1, "R10 activate took effect");
        issue(CMD_REF);
        chk_code(3, "R9 refresh with bank busy");
        issue(CMD_MRS);
        chk_code(3, "R9 mode load with bank open");

        // R10: mode register set
        fresh();
        issue(CMD_MRS);
        chk_code(0, "R10 mode load");
        issue(CMD_MRS);
        chk_code(4, "R10 mode locked");
        issue(CMD_ACT, 1);
        chk_code(0, "R10 free at n+T_MRD");

        // R3: clock enable gating
        fresh();
        cke = 1'b0;
        issue(CMD_RD, 0);
        chk_code(0, "R3 cke low now");
        cke = 1'b1;
        issue(CMD_ACT, 0);
        chk_code(0, "R3 cke low before");
        chk_state(0, 0, "R3 activate ignored");
        issue(CMD_RD, 0);
        chk_code(2, "R3 checked again");

        // R1: deselect with active-looking lines
        fresh();
        issue(CMD_DESEL, 0);
        chk_code(0, "R1 deselect");
        chk_state(0, 0, "R1 deselect no change");
        issue(CMD_NOP);
        chk_code(0, "R1 nop");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule